// File: doc/BRIEF.md
# Segment Descriptor Cache Unit

This block keeps one hidden descriptor per segment selector register: one code segment, one stack segment and four data segments, six entries in all. Each entry holds a base address, a limit and three attribute bits (present, writable, executable). A load strobe writes one entry. How the entry is written depends on the current mode. In real mode, the base is taken from the selector shifted left by four bits, and the limit and attributes are forced to their fixed real-mode values. In protected mode, the base, limit and attributes are all copied from a descriptor that arrives on input ports. Those ports stand in for the table fetch that the selector would index.

On each memory reference, the block picks the named entry and adds its base to the offset to form a 32-bit linear address. It also checks the offset against the limit and the reference type against the attribute bits. One cycle later the block raises either an address-valid strobe carrying the linear address or a fault pulse, never both.

Segment indices 0 to 5 name the six entries, with 0 the code segment and 1 the stack segment. The block has no table walking, paging or privilege checking.

Top module: `seg_cache_unit`

## Requirements
- R1: After reset, lin_valid and ref_fault are low, and every entry holds base 0, limit 0x0000FFFF and all three attributes set.
- R2: A load with prot_mode low writes the target entry as follows: base = zero-extended {ld_sel, 4'b0000}, limit = 0x0000FFFF, present, writable and executable all set. References made from the next cycle on see the new values.
- R3: A load with prot_mode high copies ld_base, ld_limit and ld_attr into the target entry. ld_attr bit 2 is present, bit 1 is writable and bit 0 is executable.
- R4: A reference that does not fault raises lin_valid for exactly the following cycle, with lin_addr = (base + ref_offset) mod 2^32. Without a reference in the previous cycle, both lin_valid and ref_fault are low.
- R5: A reference whose ref_offset is greater than the entry's limit raises ref_fault for one cycle and leaves lin_valid low. An offset equal to the limit is legal. lin_valid and ref_fault are never high together.
- R6: ref_kind encodes the reference type: 0 is a read, 1 a write, 2 an instruction fetch, and 3 is treated as a read. A write to an entry whose writable bit is clear faults. A read from the same entry does not fault.
- R7: A fetch (ref_kind 2) from an entry whose executable bit is clear faults.
- R8: A reference of any type to an entry whose present bit is clear faults.
- R9: Segment indices 6 and 7 name no entry. A load to either of them has no effect, and a reference to either of them faults.
- R10: A load changes only the entry it names. The other entries keep their base, limit and attributes.
- R11: When a load and a reference to the same entry occur in the same cycle, the reference uses the entry's contents from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode | input | 1 | 0 = real mode, 1 = protected mode; selects the load rule |
| ld_valid | input | 1 | Load strobe |
| ld_seg | input | 3 | Entry index for the load |
| ld_sel | input | 16 | Selector value, used by real-mode loads |
| ld_base | input | 32 | Fetched descriptor base, used by protected-mode loads |
| ld_limit | input | 32 | Fetched descriptor limit, used by protected-mode loads |
| ld_attr | input | 3 | Fetched attributes {present, writable, executable} |
| ref_valid | input | 1 | Memory reference strobe |
| ref_seg | input | 3 | Entry index for the reference |
| ref_kind | input | 2 | Reference type (0 read, 1 write, 2 fetch, 3 read) |
| ref_offset | input | 32 | Offset within the segment |
| lin_valid | output | 1 | Linear address valid, one cycle after a clean reference |
| lin_addr | output | 32 | Linear address |
| ref_fault | output | 1 | Limit, type, presence or index fault, one cycle after the reference |

## Verification
The bench builds the block with its default parameters: six entries, a 3-bit index, a 16-bit selector and a 32-bit address. With these values the index field can encode two values that name no entry, so the bench can drive loads and references at indices 6 and 7. The 32-bit address width lets a protected-mode base near the top of the address space wrap the linear address past 2^32. A limit of all ones and the real-mode limit of 0xFFFF let the bench test offsets one below, at and one above each limit.

// File: rtl/seg_cache_pkg.sv
package seg_cache_pkg;

    typedef struct packed {
        logic present;
        logic writable;
        logic executable;
    } seg_attr_t;

    localparam int ATTR_W = $bits(seg_attr_t);

    typedef enum logic [1:0] {
        ACC_READ     = 2'd0,
        ACC_WRITE    = 2'd1,
        ACC_FETCH    = 2'd2,
        ACC_READ_ALT = 2'd3
    } acc_kind_t;

endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
    import seg_cache_pkg::*;
#(
    parameter int NUM_SEG       = 6,
    parameter int SEG_IDX_W     = 3,
    parameter int SEL_W         = 16,
    parameter int ADDR_W        = 32,
    parameter int SEL_SHIFT     = 4,
    parameter int REAL_SEG_BITS = 16,
    localparam int DESC_W       = 2 * ADDR_W + ATTR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prot_mode,
    input  logic                 ld_valid,
    input  logic [SEG_IDX_W-1:0] ld_seg,
    input  logic [SEL_W-1:0]     ld_sel,
    input  logic [ADDR_W-1:0]    ld_base,
    input  logic [ADDR_W-1:0]    ld_limit,
    input  logic [ATTR_W-1:0]    ld_attr,
    output logic [DESC_W-1:0]    desc_q [NUM_SEG]
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        seg_attr_t         attr;
    } desc_t;

    localparam logic [ADDR_W-1:0] REAL_LIMIT = ADDR_W'((64'd1 << REAL_SEG_BITS) - 64'd1);
    localparam seg_attr_t REAL_ATTR = '{present: 1'b1, writable: 1'b1, executable: 1'b1};
    localparam desc_t RESET_ENT = '{base: '0, limit: REAL_LIMIT, attr: REAL_ATTR};

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        desc_t ent_d;
        desc_t ent_q;
        logic  hit;

        assign hit = ld_valid && (ld_seg == SEG_IDX_W'(g));

        always_comb begin
            ent_d = ent_q;
            if (hit) begin
                if (prot_mode) begin
                    ent_d.base  = ld_base;
                    ent_d.limit = ld_limit;
                    ent_d.attr  = seg_attr_t'(ld_attr);
                end else begin
                    ent_d.base  = ADDR_W'({ld_sel, {SEL_SHIFT{1'b0}}});
                    ent_d.limit = REAL_LIMIT;
                    ent_d.attr  = REAL_ATTR;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= RESET_ENT;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign desc_q[g] = ent_q;
    end

endmodule

// File: rtl/seg_ref_check.sv
module seg_ref_check
    import seg_cache_pkg::*;
#(
    parameter int NUM_SEG   = 6,
    parameter int SEG_IDX_W = 3,
    parameter int ADDR_W    = 32,
    localparam int DESC_W   = 2 * ADDR_W + ATTR_W
) (
    input  logic [DESC_W-1:0]    desc_q [NUM_SEG],
    input  logic [SEG_IDX_W-1:0] ref_seg,
    input  logic [1:0]           ref_kind,
    input  logic [ADDR_W-1:0]    ref_offset,
    output logic [ADDR_W-1:0]    chk_addr,
    output logic                 chk_fault
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        seg_attr_t         attr;
    } desc_t;

    desc_t     ent;
    logic      seg_ok;
    logic      over_limit;
    logic      type_bad;
    acc_kind_t kind;

    always_comb begin
        ent    = '0;
        seg_ok = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (ref_seg == SEG_IDX_W'(i)) begin
                ent    = desc_t'(desc_q[i]);
                seg_ok = 1'b1;
            end
        end
    end

    always_comb begin
        kind       = acc_kind_t'(ref_kind);
        chk_addr   = ent.base + ref_offset;
        over_limit = ref_offset > ent.limit;
        type_bad   = ((kind == ACC_WRITE) && !ent.attr.writable) ||
                     ((kind == ACC_FETCH) && !ent.attr.executable);
        chk_fault  = !seg_ok || !ent.attr.present || over_limit || type_bad;
    end

endmodule

// File: rtl/seg_cache_unit.sv
module seg_cache_unit
    import seg_cache_pkg::*;
#(
    parameter int NUM_SEG       = 6,
    parameter int SEG_IDX_W     = 3,
    parameter int SEL_W         = 16,
    parameter int ADDR_W        = 32,
    parameter int SEL_SHIFT     = 4,
    parameter int REAL_SEG_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prot_mode,
    input  logic                 ld_valid,
    input  logic [SEG_IDX_W-1:0] ld_seg,
    input  logic [SEL_W-1:0]     ld_sel,
    input  logic [ADDR_W-1:0]    ld_base,
    input  logic [ADDR_W-1:0]    ld_limit,
    input  logic [2:0]           ld_attr,
    input  logic                 ref_valid,
    input  logic [SEG_IDX_W-1:0] ref_seg,
    input  logic [1:0]           ref_kind,
    input  logic [ADDR_W-1:0]    ref_offset,
    output logic                 lin_valid,
    output logic [ADDR_W-1:0]    lin_addr,
    output logic                 ref_fault
);

    localparam int DESC_W = 2 * ADDR_W + ATTR_W;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              fault;
    } out_t;

    logic [DESC_W-1:0] desc_q [NUM_SEG];
    logic [ADDR_W-1:0] chk_addr;
    logic              chk_fault;
    out_t              out_d;
    out_t              out_q;

    seg_desc_file #(
        .NUM_SEG      (NUM_SEG),
        .SEG_IDX_W    (SEG_IDX_W),
        .SEL_W        (SEL_W),
        .ADDR_W       (ADDR_W),
        .SEL_SHIFT    (SEL_SHIFT),
        .REAL_SEG_BITS(REAL_SEG_BITS)
    ) u_desc (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_mode(prot_mode),
        .ld_valid (ld_valid),
        .ld_seg   (ld_seg),
        .ld_sel   (ld_sel),
        .ld_base  (ld_base),
        .ld_limit (ld_limit),
        .ld_attr  (ld_attr),
        .desc_q   (desc_q)
    );

    seg_ref_check #(
        .NUM_SEG  (NUM_SEG),
        .SEG_IDX_W(SEG_IDX_W),
        .ADDR_W   (ADDR_W)
    ) u_check (
        .desc_q    (desc_q),
        .ref_seg   (ref_seg),
        .ref_kind  (ref_kind),
        .ref_offset(ref_offset),
        .chk_addr  (chk_addr),
        .chk_fault (chk_fault)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = ref_valid && !chk_fault;
        out_d.fault = ref_valid && chk_fault;
        if (ref_valid) begin
            out_d.addr = chk_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign lin_valid = out_q.valid;
    assign lin_addr  = out_q.addr;
    assign ref_fault = out_q.fault;

endmodule

// File: rtl/seg_cache_chk.sv
module seg_cache_chk
    import seg_cache_pkg::*;
#(
    parameter int NUM_SEG       = 6,
    parameter int SEG_IDX_W     = 3,
    parameter int SEL_W         = 16,
    parameter int ADDR_W        = 32,
    parameter int SEL_SHIFT     = 4,
    parameter int REAL_SEG_BITS = 16,
    localparam int DESC_W       = 2 * ADDR_W + ATTR_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 prot_mode,
    input logic                 ld_valid,
    input logic [SEG_IDX_W-1:0] ld_seg,
    input logic [SEL_W-1:0]     ld_sel,
    input logic [ADDR_W-1:0]    ld_base,
    input logic [ADDR_W-1:0]    ld_limit,
    input logic [2:0]           ld_attr,
    input logic                 ref_valid,
    input logic [SEG_IDX_W-1:0] ref_seg,
    input logic [1:0]           ref_kind,
    input logic [ADDR_W-1:0]    ref_offset,
    input logic                 lin_valid,
    input logic [ADDR_W-1:0]    lin_addr,
    input logic                 ref_fault,
    input logic [DESC_W-1:0]    desc_q [NUM_SEG]
);

    localparam logic [SEG_IDX_W-1:0] SEG_LAST = SEG_IDX_W'(NUM_SEG - 1);
    localparam logic [ADDR_W-1:0] REAL_LIMIT = ADDR_W'((64'd1 << REAL_SEG_BITS) - 64'd1);

    logic [SEG_IDX_W-1:0] ld_seg_q;
    logic [DESC_W-1:0]    tgt_ent;
    logic [DESC_W-1:0]    cur_ent;
    logic [ADDR_W-1:0]    tgt_base;
    logic [ADDR_W-1:0]    tgt_limit;
    logic [2:0]           tgt_attr;
    logic [ADDR_W-1:0]    cur_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_seg_q <= '0;
        end else begin
            ld_seg_q <= ld_seg;
        end
    end

    always_comb begin
        tgt_ent = '0;
        cur_ent = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (ld_seg_q == SEG_IDX_W'(i)) tgt_ent = desc_q[i];
            if (ref_seg == SEG_IDX_W'(i))  cur_ent = desc_q[i];
        end
        tgt_base  = tgt_ent[DESC_W-1 -: ADDR_W];
        tgt_limit = tgt_ent[ATTR_W +: ADDR_W];
        tgt_attr  = tgt_ent[ATTR_W-1:0];
        cur_limit = cur_ent[ATTR_W +: ADDR_W];
    end

    // R2
    real_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !prot_mode && ld_seg <= SEG_LAST) |=>
        (tgt_base == ADDR_W'({$past(ld_sel), {SEL_SHIFT{1'b0}}}) &&
         tgt_limit == REAL_LIMIT && tgt_attr == 3'b111));

    // R3
    prot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && prot_mode && ld_seg <= SEG_LAST) |=>
        (tgt_base == $past(ld_base) && tgt_limit == $past(ld_limit) &&
         tgt_attr == $past(ld_attr)));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |=> (!lin_valid && !ref_fault));

    // R5
    limit_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_seg <= SEG_LAST && ref_offset > cur_limit) |=> ref_fault);

    // R5
    valid_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lin_valid && ref_fault));

    // R9
    bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_seg > SEG_LAST) |=> (ref_fault && !lin_valid));

endmodule

bind seg_cache_unit seg_cache_chk #(
    .NUM_SEG      (NUM_SEG),
    .SEG_IDX_W    (SEG_IDX_W),
    .SEL_W        (SEL_W),
    .ADDR_W       (ADDR_W),
    .SEL_SHIFT    (SEL_SHIFT),
    .REAL_SEG_BITS(REAL_SEG_BITS)
) u_chk (.*);

// File: tb/seg_cache_unit_tb.sv
module seg_cache_unit_tb;

    typedef struct packed {
        logic        prot;
        logic        ld_v;
        logic [2:0]  ld_seg;
        logic [15:0] ld_sel;
        logic [31:0] ld_base;
        logic [31:0] ld_limit;
        logic [2:0]  ld_attr;
        logic        ref_v;
        logic [2:0]  ref_seg;
        logic [1:0]  kind;
        logic [31:0] off;
        logic        exp_v;
        logic [31:0] exp_addr;
        logic        exp_f;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 23;

    localparam vec_t VECS [NVEC] = '{
        // R2 real-mode load of entry 0 with selector 0x1234
        '{1'b0, 1'b1, 3'd0, 16'h1234, 32'h0, 32'h0, 3'b000, 1'b0, 3'd0, 2'd0, 32'h0,     1'b0, 32'h0,        1'b0, 4'd2},
        // R2 R4 read at offset 0x10
        '{1'b0, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd0, 2'd0, 32'h10,    1'b1, 32'h00012350, 1'b0, 4'd4},
        // R5 offset equal to limit
        '{1'b0, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd0, 2'd0, 32'hFFFF,  1'b1, 32'h0002233F, 1'b0, 4'd5},
        // R5 offset one past limit
        '{1'b0, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd0, 2'd0, 32'h10000, 1'b0, 32'h0,        1'b1, 4'd5},
        // R10 entry 1 untouched, fetch allowed
        '{1'b0, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd1, 2'd2, 32'h20,    1'b1, 32'h00000020, 1'b0, 4'd10},
        // R3 protected load entry 2: P,W, not X
        '{1'b1, 1'b1, 3'd2, 16'h0, 32'hFFFFFF00, 32'h000FFFFF, 3'b110, 1'b0, 3'd0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 4'd3},
        // R4 write with wrap past 2^32
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd2, 2'd1, 32'h200,   1'b1, 32'h00000100, 1'b0, 4'd4},
        // R7 fetch from non-executable
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd2, 2'd2, 32'h0,     1'b0, 32'h0,        1'b1, 4'd7},
        // R3 protected load entry 3: P,X, not W, limit 0xFFF
        '{1'b1, 1'b1, 3'd3, 16'h0, 32'h00400000, 32'h00000FFF, 3'b101, 1'b0, 3'd0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 4'd3},
        // R6 write to non-writable
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd3, 2'd1, 32'h4,     1'b0, 32'h0,        1'b1, 4'd6},
        // R6 read from same entry at limit
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd3, 2'd0, 32'hFFF,   1'b1, 32'h00400FFF, 1'b0, 4'd6},
        // R5 fetch one past limit
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd3, 2'd2, 32'h1000,  1'b0, 32'h0,        1'b1, 4'd5},
        // R3 protected load entry 4, not present
        '{1'b1, 1'b1, 3'd4, 16'h0, 32'h00001000, 32'hFFFFFFFF, 3'b011, 1'b0, 3'd0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b0, 4'd3},
        // R8 read from non-present
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd4, 2'd0, 32'h0,     1'b0, 32'h0,        1'b1, 4'd8},
        // R9 load to index 6 with reference to index 6
        '{1'b1, 1'b1, 3'd6, 16'h0, 32'h00005000, 32'h0000FFFF, 3'b111, 1'b1, 3'd6, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 4'd9},
        // R9 reference to index 7
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd7, 2'd0, 32'h0,     1'b0, 32'h0,        1'b1, 4'd9},
        // R11 load and reference to entry 5 in one cycle: old base 0
        '{1'b1, 1'b1, 3'd5, 16'h0, 32'hABC00000, 32'h000000FF, 3'b111, 1'b1, 3'd5, 2'd0, 32'h10, 1'b1, 32'h00000010, 1'b0, 4'd11},
        // R3 new entry 5 visible
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd5, 2'd0, 32'h10,    1'b1, 32'hABC00010, 1'b0, 4'd3},
        // R6 kind 3 behaves as read, within limit
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd5, 2'd3, 32'h80,    1'b1, 32'hABC00080, 1'b0, 4'd6},
        // R5 kind 3 beyond limit
        '{1'b1, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd5, 2'd3, 32'h100,   1'b0, 32'h0,        1'b1, 4'd5},
        // R2 real-mode reload of entry 2 restores full attributes
        '{1'b0, 1'b1, 3'd2, 16'hFFFF, 32'h0, 32'h0, 3'b000, 1'b0, 3'd0, 2'd0, 32'h0,     1'b0, 32'h0,        1'b0, 4'd2},
        // R2 fetch now allowed, limit 0xFFFF
        '{1'b0, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd2, 2'd2, 32'hFFFF,  1'b1, 32'h0010FFEF, 1'b0, 4'd2},
        // R10 entry 0 unchanged by later loads
        '{1'b0, 1'b0, 3'd0, 16'h0,    32'h0, 32'h0, 3'b000, 1'b1, 3'd0, 2'd0, 32'h10,    1'b1, 32'h00012350, 1'b0, 4'd10}
    };

    logic        clk;
    logic        rst_n;
    logic        prot_mode;
    logic        ld_valid;
    logic [2:0]  ld_seg;
    logic [15:0] ld_sel;
    logic [31:0] ld_base;
    logic [31:0] ld_limit;
    logic [2:0]  ld_attr;
    logic        ref_valid;
    logic [2:0]  ref_seg;
    logic [1:0]  ref_kind;
    logic [31:0] ref_offset;
    logic        lin_valid;
    logic [31:0] lin_addr;
    logic        ref_fault;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    seg_cache_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_mode (prot_mode),
        .ld_valid  (ld_valid),
        .ld_seg    (ld_seg),
        .ld_sel    (ld_sel),
        .ld_base   (ld_base),
        .ld_limit  (ld_limit),
        .ld_attr   (ld_attr),
        .ref_valid (ref_valid),
        .ref_seg   (ref_seg),
        .ref_kind  (ref_kind),
        .ref_offset(ref_offset),
        .lin_valid (lin_valid),
        .lin_addr  (lin_addr),
        .ref_fault (ref_fault)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic drive_idle();
        ld_valid   = 1'b0;
        ld_seg     = 3'd0;
        ld_sel     = 16'h0;
        ld_base    = 32'h0;
        ld_limit   = 32'h0;
        ld_attr    = 3'b000;
        ref_valid  = 1'b0;
        ref_seg    = 3'd0;
        ref_kind   = 2'd0;
        ref_offset = 32'h0;
    endtask

    task automatic check(input string tag, input logic ev, input logic [31:0] ea, input logic ef);
        n_checks = n_checks + 1;
        if (lin_valid !== ev || ref_fault !== ef || (ev && lin_addr !== ea)) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual valid=%0b addr=%08h fault=%0b expected valid=%0b addr=%08h fault=%0b",
                     tag, lin_valid, lin_addr, ref_fault, ev, ea, ef);
        end
    endtask

    task automatic do_ref(input logic [2:0] seg, input logic [1:0] kind, input logic [31:0] off);
        @(negedge clk);
        drive_idle();
        ref_valid  = 1'b1;
        ref_seg    = seg;
        ref_kind   = kind;
        ref_offset = off;
        @(negedge clk);
        drive_idle();
    endtask

    initial begin
        rst_n     = 1'b0;
        prot_mode = 1'b0;
        drive_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 outputs low after reset
        check("R1 reset outputs", 1'b0, 32'h0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            prot_mode  = VECS[i].prot;
            ld_valid   = VECS[i].ld_v;
            ld_seg     = VECS[i].ld_seg;
            ld_sel     = VECS[i].ld_sel;
            ld_base    = VECS[i].ld_base;
            ld_limit   = VECS[i].ld_limit;
            ld_attr    = VECS[i].ld_attr;
            ref_valid  = VECS[i].ref_v;
            ref_seg    = VECS[i].ref_seg;
            ref_kind   = VECS[i].kind;
            ref_offset = VECS[i].off;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  VECS[i].exp_v, VECS[i].exp_addr, VECS[i].exp_f);
        end

        // R4 idle cycle: no strobe, no fault
        drive_idle();
        @(negedge clk);
        check("R4 idle", 1'b0, 32'h0, 1'b0);

        // R1 reset restores entries to base 0, limit 0xFFFF, full attributes
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 outputs in reset", 1'b0, 32'h0, 1'b0);
        rst_n = 1'b1;
        do_ref(3'd0, 2'd0, 32'h5);
        check("R1 entry 0 base cleared", 1'b1, 32'h00000005, 1'b0);
        do_ref(3'd3, 2'd1, 32'hFFFF);
        check("R1 entry 3 writable at limit", 1'b1, 32'h0000FFFF, 1'b0);
        do_ref(3'd3, 2'd2, 32'h10000);
        check("R1 entry 3 limit 0xFFFF", 1'b0, 32'h0, 1'b1);
        do_ref(3'd4, 2'd2, 32'h0);
        check("R1 entry 4 present and executable", 1'b1, 32'h0, 1'b0);

        // R9 index 6 load left entries 0..5 untouched and index 6 still faults
        do_ref(3'd6, 2'd0, 32'h0);
        check("R9 index 6 faults", 1'b0, 32'h0, 1'b1);

        // R4 strobe lasts one cycle only
        @(negedge clk);
        check("R4 single cycle", 1'b0, 32'h0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule